// File: doc/BRIEF.md
# Beat-Tag Phase Error Extractor

This block sits between a dual-mixer time-difference front end and two oscillator control loops. The front end delivers two free-running beat-note timestamps, one for the reference clock and one for the main clock. Each comes with a one-cycle capture strobe. The block reduces all arithmetic modulo a fixed beat period of 32768 counts and maps each result into a signed window centred on zero.

Every reference capture produces an updated period error, the negated reference tag after wrapping. That error feeds the helper oscillator loop and does not wait for the main tag. The phase error is the main tag minus the reference tag, after wrapping. It is flagged ready only once both tags have arrived since it was last consumed. The main loop consumes it with an acknowledge, which re-arms both arrival flags. The stored tags keep their values.

Top module: `beat_phase_extract`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `per_err_o` = 0, `per_vld_o` = 0, `ph_rdy_o` = 0 and `ph_err_o` = 0. Both stored tags become zero.
- R2: A high `ref_stb_i` at an edge makes `per_vld_o` high for exactly the next cycle. From that cycle `per_err_o` holds wrap((0 − ref_tag_i) mod 32768) until the next reference strobe.
- R3: `ph_err_o` always equals wrap((main − ref) mod 32768), where main and ref are the most recently captured tags. It changes only in the cycle after a capture.
- R4: Only bits [14:0] of each tag affect any result. Bits [31:15] are ignored.
- R5: The wrap of a reduced value m in 0..32767 is m − 32768 when m > 16384, and m otherwise. Both error outputs are 16-bit two's complement in −16383..+16384, and 16384 stays positive.
- R6: A reference capture updates the period error whether or not a main tag has been captured.
- R7: `ph_rdy_o` is high exactly when both tags have been captured since reset or since the last consumed acknowledge. It rises in the cycle after the second capture.
- R8: `ph_ack_i` high while `ph_rdy_o` is high clears both arrival flags at that edge. `ph_err_o` keeps its value.
- R9: `ph_ack_i` high while `ph_rdy_o` is low has no effect on any flag.
- R10: When both strobes are high at the same edge, both tags are captured. The period error from the new reference tag and `ph_rdy_o` with the phase error of both new tags appear in the next cycle.
- R11: A strobe at the same edge as a consumed acknowledge re-sets that strobe's own arrival flag. The other flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tag_i | input | 32 | Reference beat timestamp |
| ref_stb_i | input | 1 | Reference tag capture strobe |
| main_tag_i | input | 32 | Main beat timestamp |
| main_stb_i | input | 1 | Main tag capture strobe |
| ph_ack_i | input | 1 | Phase error consumed |
| per_err_o | output | 16 | Signed period error |
| per_vld_o | output | 1 | Period error update pulse |
| ph_err_o | output | 16 | Signed phase error |
| ph_rdy_o | output | 1 | Phase error ready |

## Verification
The hardest situations to reach are the collisions. One is an acknowledge that lands on the same edge as one or both strobes. Another is an acknowledge that arrives while only one tag is pending. A third is reduced values sitting exactly on the 16384 boundary. Directed sequences place tags whose low 15 bits give differences of 16384 and 16385, with junk in the upper bits. Directed sequences also line up acknowledges with strobes. A long random phase then draws strobes, acknowledges and occasional resets independently each cycle. This produces many overlapping orders, and a bench model tracks the flags and wrapped errors across them.

// File: rtl/beat_err_pkg.sv
package beat_err_pkg;

    localparam int BEAT_W = 15;
    localparam int ERR_W  = BEAT_W + 1;
    localparam logic [BEAT_W-1:0] HALF_BEAT = BEAT_W'(1 << (BEAT_W - 1));

    typedef logic [BEAT_W-1:0]        beat_t;
    typedef logic signed [ERR_W-1:0]  err_t;

    typedef struct packed {
        beat_t tag;
        logic  rdy;
    } slot_t;

    // Map a residue in [0, period) onto (-half, +half]
    function automatic err_t wrap_err(input beat_t r);
        if (r > HALF_BEAT)
            return err_t'({1'b1, r});
        else
            return err_t'({1'b0, r});
    endfunction

endpackage

// File: rtl/beat_tag_slot.sv
module beat_tag_slot
    import beat_err_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb_i,
    input  beat_t tag_i,
    input  logic  clr_i,
    output slot_t slot_o
);

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            if (stb_i)
                slot_q.tag <= tag_i;
            if (stb_i)
                slot_q.rdy <= 1'b1;
            else if (clr_i)
                slot_q.rdy <= 1'b0;
        end
    end

    assign slot_o = slot_q;

    // R3
    tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(slot_o.tag));

    // R11
    capture_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        stb_i |=> slot_o.rdy);

endmodule

// File: rtl/beat_period_unit.sv
module beat_period_unit
    import beat_err_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb_i,
    input  beat_t tag_i,
    output err_t  err_o,
    output logic  vld_o
);

    beat_t neg_tag;
    err_t  err_q;
    logic  vld_q;

    assign neg_tag = beat_t'(0) - tag_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= stb_i;
            if (stb_i)
                err_q <= wrap_err(neg_tag);
        end
    end

    assign err_o = err_q;
    assign vld_o = vld_q;

    // R5
    per_range_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (err_o >= -16'sd16383) && (err_o <= 16'sd16384));

    // R2
    per_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> !vld_o && $stable(err_o));

endmodule

// File: rtl/beat_phase_unit.sv
module beat_phase_unit
    import beat_err_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t ref_i,
    input  slot_t main_i,
    input  logic  ack_i,
    output err_t  err_o,
    output logic  rdy_o,
    output logic  clr_o
);

    beat_t diff;

    assign diff  = main_i.tag - ref_i.tag;
    assign err_o = wrap_err(diff);
    assign rdy_o = ref_i.rdy & main_i.rdy;
    assign clr_o = ack_i & rdy_o;

    // R7
    rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_o && !ack_i |=> rdy_o);

    // R5
    ph_range_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o >= -16'sd16383) && (err_o <= 16'sd16384));

endmodule

// File: rtl/beat_phase_extract.sv
module beat_phase_extract
    import beat_err_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [TAG_W-1:0]        ref_tag_i,
    input  logic                    ref_stb_i,
    input  logic [TAG_W-1:0]        main_tag_i,
    input  logic                    main_stb_i,
    input  logic                    ph_ack_i,
    output logic signed [ERR_W-1:0] per_err_o,
    output logic                    per_vld_o,
    output logic signed [ERR_W-1:0] ph_err_o,
    output logic                    ph_rdy_o
);

    localparam int HI_W = TAG_W - BEAT_W;

    beat_t ref_lo, main_lo;
    slot_t ref_slot, main_slot;
    logic  clr;
    err_t  per_err, ph_err;

    // R4: upper tag bits carry no information modulo the beat period
    assign ref_lo  = ref_tag_i[BEAT_W-1:0];
    assign main_lo = main_tag_i[BEAT_W-1:0];

    logic unused_hi;
    assign unused_hi = ^{ref_tag_i[TAG_W-1 -: HI_W], main_tag_i[TAG_W-1 -: HI_W]};

    beat_tag_slot u_ref_slot (
        .clk(clk), .rst(rst), .stb_i(ref_stb_i), .tag_i(ref_lo),
        .clr_i(clr), .slot_o(ref_slot)
    );

    beat_tag_slot u_main_slot (
        .clk(clk), .rst(rst), .stb_i(main_stb_i), .tag_i(main_lo),
        .clr_i(clr), .slot_o(main_slot)
    );

    beat_period_unit u_period (
        .clk(clk), .rst(rst), .stb_i(ref_stb_i), .tag_i(ref_lo),
        .err_o(per_err), .vld_o(per_vld_o)
    );

    beat_phase_unit u_phase (
        .clk(clk), .rst(rst), .ref_i(ref_slot), .main_i(main_slot),
        .ack_i(ph_ack_i), .err_o(ph_err), .rdy_o(ph_rdy_o), .clr_o(clr)
    );

    assign per_err_o = per_err;
    assign ph_err_o  = ph_err;

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ph_rdy_o && ph_ack_i && !ref_stb_i && !main_stb_i |=> !ph_rdy_o && $stable(ph_err_o));

    // R9
    ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !ph_rdy_o && !ref_stb_i && !main_stb_i |=> !ph_rdy_o);

    // R6
    ref_update_chk: assert property (@(posedge clk) disable iff (rst)
        ref_stb_i |=> per_vld_o);

    // R10
    both_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ref_stb_i && main_stb_i |=> ph_rdy_o && per_vld_o);

    // R1
    reset_chk: assert property (@(posedge clk)
        rst |=> !ph_rdy_o && !per_vld_o && per_err_o == 0 && ph_err_o == 0);

endmodule

// File: tb/beat_phase_extract_test.sv
`timescale 1ns/1ps
module beat_phase_extract_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] ref_tag = '0, main_tag = '0;
    logic ref_stb = 1'b0, main_stb = 1'b0, ack = 1'b0;
    logic signed [15:0] per_err, ph_err;
    logic per_vld, ph_rdy;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model state
    int m_ref = 0, m_main = 0, m_per = 0;
    bit m_rf = 0, m_mf = 0, m_vld = 0;

    always #2.5 clk = ~clk;

    beat_phase_extract uut (
        .clk(clk), .rst(rst),
        .ref_tag_i(ref_tag), .ref_stb_i(ref_stb),
        .main_tag_i(main_tag), .main_stb_i(main_stb),
        .ph_ack_i(ack),
        .per_err_o(per_err), .per_vld_o(per_vld),
        .ph_err_o(ph_err), .ph_rdy_o(ph_rdy)
    );

    function automatic int wrapm(input int d);
        int m;
        m = d & 32'h7FFF;
        if (m > 16384) m = m - 32768;
        return m;
    endfunction

    task automatic chk(input string req, input string ctx, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, ctx, act, exp);
        end
    endtask

    task automatic cyc(input bit r, input bit rs, input logic [31:0] rt,
                       input bit ms, input logic [31:0] mt, input bit a, input string ctx);
        bit eff;
        @(negedge clk);
        rst = r; ref_stb = rs; ref_tag = rt; main_stb = ms; main_tag = mt; ack = a;
        @(posedge clk);
        #1;
        if (r) begin
            m_ref = 0; m_main = 0; m_per = 0; m_rf = 0; m_mf = 0; m_vld = 0;
        end else begin
            eff = a && m_rf && m_mf;
            m_vld = rs;
            if (rs) begin
                m_ref = int'(rt & 32'h7FFF);
                m_per = wrapm(-int'(rt & 32'h7FFF));
            end
            if (ms) m_main = int'(mt & 32'h7FFF);
            m_rf = rs ? 1'b1 : (eff ? 1'b0 : m_rf);
            m_mf = ms ? 1'b1 : (eff ? 1'b0 : m_mf);
        end
        chk("R2", ctx, int'(per_vld), int'(m_vld));
        chk("R2", ctx, int'(per_err), m_per);
        chk("R3", ctx, int'(ph_err), wrapm(m_main - m_ref));
        chk("R7", ctx, int'(ph_rdy), int'(m_rf && m_mf));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(1, 0, 0, 0, 0, 0, "R1 reset");
        cyc(1, 0, 0, 0, 0, 0, "R1 reset");
        chk("R1", "reset per_err", int'(per_err), 0);
        chk("R1", "reset ph_rdy", int'(ph_rdy), 0);
        // period error without any main tag
        cyc(0, 1, 32'h0000_3FFF, 0, 0, 0, "R6 ref only, R5 -16383");
        chk("R5", "neg 0x3FFF", int'(per_err), -16383);
        cyc(0, 1, 32'hFFFF_C000, 0, 0, 0, "R4 R5 half stays positive");
        chk("R5", "neg 0x4000", int'(per_err), 16384);
        cyc(0, 0, 0, 0, 0, 1, "R9 ack not ready");
        cyc(0, 0, 0, 0, 0, 0, "R2 hold");
        // main arrives: phase ready
        cyc(0, 0, 0, 1, 32'hABCD_8000, 0, "R7 R4 main arrival");
        chk("R5", "diff 0x4000", int'(ph_err), 16384);
        cyc(0, 0, 0, 0, 0, 0, "R7 hold");
        cyc(0, 0, 0, 0, 0, 1, "R8 consume");
        chk("R8", "rdy after ack", int'(ph_rdy), 0);
        chk("R8", "err kept", int'(ph_err), 16384);
        // R10 simultaneous capture
        cyc(0, 1, 32'h1234_0010, 1, 32'h0000_4011, 0, "R10 both");
        chk("R5", "diff 0x4001", int'(ph_err), -16383);
        // R11 strobe with consuming ack
        cyc(0, 0, 0, 1, 32'h0000_0005, 1, "R11 main with ack");
        chk("R11", "rdy after main+ack", int'(ph_rdy), 0);
        cyc(0, 1, 32'h0000_0007, 0, 0, 0, "R11 ref completes");
        chk("R11", "rdy after ref", int'(ph_rdy), 1);
        chk("R3", "5-7", int'(ph_err), -2);
        cyc(0, 1, 32'h0000_0001, 1, 32'h0000_0002, 1, "R11 both with ack");
        chk("R11", "rdy both+ack", int'(ph_rdy), 1);
        cyc(0, 0, 0, 0, 0, 0, "idle");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 200) == 0, ($urandom % 3) == 0, $urandom,
                ($urandom % 3) == 0, $urandom, ($urandom % 2) == 0, "random R1 R6 R9");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule